// File: doc/BRIEF.md
# Multi-Mode Register Bit-Field Cell

This block is one control/status field of a register bank. A single parameter, `MODE`, picks how software access behaves: plain storage, hardware-fed read-only, clear-or-set on read, bit-wise clear-or-set on write, a write effect combined with the opposite read effect, write-once locking, or a reserved slot. The register bank in front of the cell does the address decoding. It presents a write strobe, a read strobe, write data and byte enables, and it takes the read data back combinationally in the same cycle.

On the hardware side, logic can feed a value into a read-only field and can force individual bits to one or to zero. A forced bit always beats whatever the bus did in that cycle. Every effect becomes visible on `field_q` after the next rising clock edge. `MODE` is of the enumerated type `bfc_pkg::field_mode_e`. Its members are declared in this order:

`FM_RW`, `FM_RO`, `FM_WO`, `FM_RCLR`, `FM_RSET`, `FM_W0CLR`, `FM_W1CLR`, `FM_W0SET`, `FM_W1SET`, `FM_W0CLR_RSET`, `FM_W1CLR_RSET`, `FM_W0SET_RCLR`, `FM_W1SET_RCLR`, `FM_ONCE_RW`, `FM_ONCE_WO`, `FM_RSVD`.

They carry the codes 0 to 15 in that order.

Top module: `bitfield_cell`

## Requirements
- R1: While `rst_n` is low at a rising edge, `field_q` loads `RESET_VAL` (zero in `FM_RSVD`) and the write-once lock is cleared.
- R2: In `FM_RW` and `FM_WO`, a write stores `bus_wdata` into every byte whose `bus_be` bit is 1 (bit k covers field bits 8k to 8k+7). Bytes with a 0 enable keep their value.
- R3: In `FM_RO`, `field_q` takes the `hw_val` of the previous cycle (apart from bits forced by R10), and bus writes have no effect.
- R4: In `FM_RCLR` every bit becomes 0 after a read, and in `FM_RSET` every bit becomes 1 after a read. Writes have no effect in either mode.
- R5: In `FM_W1CLR` / `FM_W0CLR`, each enabled written bit equal to 1 / 0 clears its field bit. In `FM_W1SET` / `FM_W0SET`, each enabled written bit equal to 1 / 0 sets its field bit. All other bits are unchanged.
- R6: `FM_W0CLR_RSET` and `FM_W1CLR_RSET` clear on write as in R5 and set the whole field on a read. `FM_W0SET_RCLR` and `FM_W1SET_RCLR` set on write as in R5 and clear the whole field on a read.
- R7: In `FM_ONCE_RW` and `FM_ONCE_WO`, only the first `bus_wr` after reset updates the field, as in R2, whatever its byte enables. Every later write is ignored until the next reset.
- R8: `bus_rdata` equals the pre-edge `field_q` when `bus_rd` is 1 in a readable mode. It is 0 when `bus_rd` is 0, and always 0 in `FM_WO`, `FM_ONCE_WO` and `FM_RSVD`.
- R9: In `FM_RSVD`, `field_q` and `bus_rdata` stay 0 whatever the writes, reads and hardware requests.
- R10: Outside `FM_RSVD`, a 1 in `hw_set` makes that bit 1 after the edge, and a 1 in `hw_clr` makes it 0. Both beat any bus effect, and `hw_set` beats `hw_clr`.
- R11: A read and a write in the same cycle apply the write effect first and the read effect second, so the read clear or read set wins.
- R12: Outside `FM_RO`, a cycle with no bus strobe and no hardware request leaves `field_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | WIDTH | Bus write data |
| bus_be | input | NBYTES | Byte enables, one per 8 field bits |
| bus_rdata | output | WIDTH | Read data, combinational |
| hw_val | input | WIDTH | Value source for `FM_RO` |
| hw_set | input | WIDTH | Per-bit hardware set request |
| hw_clr | input | WIDTH | Per-bit hardware clear request |
| field_q | output | WIDTH | Current field value |

## Verification
A corrupted stored value shows up on `field_q` at the edge that corrupts it. Because `bus_rdata` returns the stored value unchanged, the same error also appears on the next read. A stuck or wrongly armed write-once lock stays hidden until the second write after reset. That write then either changes the field when it must not, or the first write fails to land, so the bench writes twice after every reset. A wrong side-effect order (write against read, or bus against hardware) is visible only in cycles where those events coincide. The bench therefore runs a long pseudo-random mix across all sixteen modes and adds directed collision cycles.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

   typedef enum logic [3:0] {
      FM_RW, FM_RO, FM_WO, FM_RCLR, FM_RSET,
      FM_W0CLR, FM_W1CLR, FM_W0SET, FM_W1SET,
      FM_W0CLR_RSET, FM_W1CLR_RSET, FM_W0SET_RCLR, FM_W1SET_RCLR,
      FM_ONCE_RW, FM_ONCE_WO, FM_RSVD
   } field_mode_e;

   typedef enum logic [2:0] {
      WK_NONE, WK_STORE, WK_CLR0, WK_CLR1, WK_SET0, WK_SET1
   } wr_kind_e;

   typedef enum logic [1:0] {
      RK_NONE, RK_CLR, RK_SET
   } rd_kind_e;

   function automatic wr_kind_e wr_kind_of(field_mode_e m);
      case (m)
         FM_RW, FM_WO, FM_ONCE_RW, FM_ONCE_WO: return WK_STORE;
         FM_W0CLR, FM_W0CLR_RSET:              return WK_CLR0;
         FM_W1CLR, FM_W1CLR_RSET:              return WK_CLR1;
         FM_W0SET, FM_W0SET_RCLR:              return WK_SET0;
         FM_W1SET, FM_W1SET_RCLR:              return WK_SET1;
         default:                              return WK_NONE;
      endcase
   endfunction

   function automatic rd_kind_e rd_kind_of(field_mode_e m);
      case (m)
         FM_RCLR, FM_W0SET_RCLR, FM_W1SET_RCLR: return RK_CLR;
         FM_RSET, FM_W0CLR_RSET, FM_W1CLR_RSET: return RK_SET;
         default:                               return RK_NONE;
      endcase
   endfunction

   function automatic bit is_readable(field_mode_e m);
      return !(m == FM_WO || m == FM_ONCE_WO || m == FM_RSVD);
   endfunction

   function automatic bit is_once(field_mode_e m);
      return (m == FM_ONCE_RW || m == FM_ONCE_WO);
   endfunction

endpackage

// File: rtl/bfc_byte_mask.sv
module bfc_byte_mask #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned NBYTES = (WIDTH + 7) / 8
) (
   input  logic [NBYTES-1:0] be,
   output logic [WIDTH-1:0]  mask
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign mask[i] = be[i / 8];
   end
endmodule

// File: rtl/bfc_wr_effect.sv
module bfc_wr_effect
   import bfc_pkg::*;
#(
   parameter int unsigned WIDTH = 16,
   parameter wr_kind_e    WK    = WK_STORE
) (
   input  logic             en,
   input  logic [WIDTH-1:0] q_in,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] q_out
);
   logic [WIDTH-1:0] hit1, hit0;

   always_comb begin
      hit1 = wdata & mask;
      hit0 = ~wdata & mask;
      q_out = q_in;
      if (en) begin
         case (WK)
            WK_STORE: q_out = (q_in & ~mask) | hit1;
            WK_CLR0:  q_out = q_in & ~hit0;
            WK_CLR1:  q_out = q_in & ~hit1;
            WK_SET0:  q_out = q_in | hit0;
            WK_SET1:  q_out = q_in | hit1;
            default:  q_out = q_in;
         endcase
      end
   end
endmodule

// File: rtl/bfc_rd_effect.sv
module bfc_rd_effect
   import bfc_pkg::*;
#(
   parameter int unsigned WIDTH = 16,
   parameter rd_kind_e    RK    = RK_NONE
) (
   input  logic             rd,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   always_comb begin
      d_out = d_in;
      if (rd) begin
         case (RK)
            RK_CLR:  d_out = '0;
            RK_SET:  d_out = {WIDTH{1'b1}};
            default: d_out = d_in;
         endcase
      end
   end
endmodule

// File: rtl/bfc_once_lock.sv
module bfc_once_lock #(
   parameter bit ENABLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   output logic allow,
   output logic locked
);
   logic lock_r;

   always_ff @(posedge clk) begin
      if (!rst_n) lock_r <= 1'b0;
      else        lock_r <= ENABLE && (lock_r || wr);
   end

   assign locked = lock_r;
   assign allow  = !lock_r;
endmodule

// File: rtl/bitfield_cell.sv
module bitfield_cell
   import bfc_pkg::*;
#(
   parameter int unsigned WIDTH     = 16,
   parameter field_mode_e MODE      = FM_RW,
   parameter logic [WIDTH-1:0] RESET_VAL = '0,
   localparam int unsigned NBYTES   = (WIDTH + 7) / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic [NBYTES-1:0] bus_be,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  hw_val,
   input  logic [WIDTH-1:0]  hw_set,
   input  logic [WIDTH-1:0]  hw_clr,
   output logic [WIDTH-1:0]  field_q
);
   localparam wr_kind_e WK       = wr_kind_of(MODE);
   localparam rd_kind_e RK       = rd_kind_of(MODE);
   localparam bit       READABLE = is_readable(MODE);
   localparam bit       ONCE     = is_once(MODE);
   localparam bit       HW_BASE  = (MODE == FM_RO);
   localparam bit       RSVD     = (MODE == FM_RSVD);
   localparam logic [WIDTH-1:0] INIT = RSVD ? '0 : RESET_VAL;

   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("bitfield_cell: WIDTH must lie in 1..64");
   end
   if (ONCE && WK != WK_STORE) begin : g_bad_once
      $error("bitfield_cell: write-once modes must store");
   end

   logic [WIDTH-1:0] q_r, q_d;
   logic [WIDTH-1:0] byte_mask, base, after_wr, after_rd;
   logic             wr_ok, wr_locked;

   bfc_byte_mask #(.WIDTH(WIDTH), .NBYTES(NBYTES)) u_mask (
      .be   (bus_be),
      .mask (byte_mask)
   );

   bfc_once_lock #(.ENABLE(ONCE)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .allow  (wr_ok),
      .locked (wr_locked)
   );

   assign base = HW_BASE ? hw_val : q_r;

   bfc_wr_effect #(.WIDTH(WIDTH), .WK(WK)) u_wr (
      .en    (bus_wr && wr_ok),
      .q_in  (base),
      .wdata (bus_wdata),
      .mask  (byte_mask),
      .q_out (after_wr)
   );

   bfc_rd_effect #(.WIDTH(WIDTH), .RK(RK)) u_rd (
      .rd    (bus_rd),
      .d_in  (after_wr),
      .d_out (after_rd)
   );

   always_comb begin
      q_d = (after_rd & ~hw_clr) | hw_set;
      if (RSVD) q_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_r <= INIT;
      else        q_r <= q_d;
   end

   assign field_q   = q_r;
   assign bus_rdata = (READABLE && bus_rd) ? q_r : '0;
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker
   import bfc_pkg::*;
#(
   parameter int unsigned WIDTH = 16,
   parameter field_mode_e MODE  = FM_RW
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [WIDTH-1:0] hw_set,
   input logic [WIDTH-1:0] hw_clr,
   input logic [WIDTH-1:0] bus_rdata,
   input logic [WIDTH-1:0] field_q,
   input logic             lock_q
);
   localparam bit IS_RSVD  = (MODE == FM_RSVD);
   localparam bit IS_HW    = (MODE == FM_RO);
   localparam bit IS_RCLR  = (rd_kind_of(MODE) == RK_CLR);
   localparam bit IS_RSET  = (rd_kind_of(MODE) == RK_SET);
   localparam bit IS_ONCE  = is_once(MODE);
   localparam bit READABLE = is_readable(MODE);

   // R8: no read data without a readable read
   a_r8_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!READABLE || !bus_rd) |-> (bus_rdata == '0));

   // R9: reserved slot stays empty
   a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      IS_RSVD |-> (field_q == '0));

   // R10: hardware set lands
   a_r10_hw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!IS_RSVD && hw_set != '0) |=> ((field_q & $past(hw_set)) == $past(hw_set)));

   // R10: hardware clear lands where set is idle
   a_r10_hw_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (!IS_RSVD && (hw_clr & ~hw_set) != '0) |=> ((field_q & $past(hw_clr & ~hw_set)) == '0));

   // R4: clear on read
   a_r4_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_RCLR && bus_rd) |=> ((field_q & ~$past(hw_set)) == '0));

   // R4: set on read
   a_r4_rd_set: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_RSET && bus_rd) |=> ((field_q | $past(hw_clr & ~hw_set)) == {WIDTH{1'b1}}));

   // R7: locked field ignores writes
   a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_ONCE && lock_q && bus_wr && hw_set == '0 && hw_clr == '0) |=> $stable(field_q));

   // R12: idle cycle holds
   a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!IS_HW && !bus_wr && !bus_rd && hw_set == '0 && hw_clr == '0) |=> $stable(field_q));
endmodule

bind bitfield_cell bfc_checker #(.WIDTH(WIDTH), .MODE(MODE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .hw_set    (hw_set),
   .hw_clr    (hw_clr),
   .bus_rdata (bus_rdata),
   .field_q   (field_q),
   .lock_q    (wr_locked)
);

// File: tb/sim_bitfield_cell.sv
module sim_bitfield_cell;
   import bfc_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 16;
   localparam int NM = 16;
   localparam logic [W-1:0] RV = 16'hA5C3;

   logic clk = 1'b0;
   logic rst_n;
   logic b_wr, b_rd;
   logic [W-1:0] b_wd, h_val, h_set, h_clr;
   logic [1:0]   b_be;
   logic [W-1:0] q_arr  [NM];
   logic [W-1:0] rd_arr [NM];

   logic [W-1:0] mq  [NM];
   logic         mlk [NM];
   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] seed = 32'h1BADF00D;

   always #(CLK_PERIOD / 2) clk = ~clk;

   for (genvar g = 0; g < NM; g++) begin : g_m
      bitfield_cell #(.WIDTH(W), .MODE(field_mode_e'(g)), .RESET_VAL(RV)) u0 (
         .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd),
         .bus_wdata(b_wd), .bus_be(b_be), .bus_rdata(rd_arr[g]),
         .hw_val(h_val), .hw_set(h_set), .hw_clr(h_clr), .field_q(q_arr[g]));
   end

   function automatic string req_of(int m);
      case (field_mode_e'(m))
         FM_RW, FM_WO:                          return "R2";
         FM_RO:                                 return "R3";
         FM_RCLR, FM_RSET:                      return "R4";
         FM_W0CLR, FM_W1CLR, FM_W0SET, FM_W1SET: return "R5";
         FM_ONCE_RW, FM_ONCE_WO:                return "R7";
         FM_RSVD:                               return "R9";
         default:                               return "R6";
      endcase
   endfunction

   function automatic bit can_read(int m);
      field_mode_e e = field_mode_e'(m);
      return !(e == FM_WO || e == FM_ONCE_WO || e == FM_RSVD);
   endfunction

   // expected next field value, derived from R2..R11
   function automatic logic [W-1:0] model_next(int m, logic [W-1:0] q, logic lk,
         logic wr, logic rd, logic [W-1:0] wd, logic [1:0] be,
         logic [W-1:0] hv, logic [W-1:0] hs, logic [W-1:0] hc);
      field_mode_e e = field_mode_e'(m);
      logic [W-1:0] msk = {{8{be[1]}}, {8{be[0]}}};
      logic [W-1:0] v = (e == FM_RO) ? hv : q;
      logic once = (e == FM_ONCE_RW || e == FM_ONCE_WO);
      if (wr && !(once && lk)) begin
         case (e)
            FM_RW, FM_WO, FM_ONCE_RW, FM_ONCE_WO: v = (v & ~msk) | (wd & msk);
            FM_W1CLR, FM_W1CLR_RSET:             v = v & ~(wd & msk);
            FM_W0CLR, FM_W0CLR_RSET:             v = v & ~(~wd & msk);
            FM_W1SET, FM_W1SET_RCLR:             v = v | (wd & msk);
            FM_W0SET, FM_W0SET_RCLR:             v = v | (~wd & msk);
            default: ;
         endcase
      end
      if (rd) begin
         if (e == FM_RCLR || e == FM_W0SET_RCLR || e == FM_W1SET_RCLR) v = '0;
         if (e == FM_RSET || e == FM_W0CLR_RSET || e == FM_W1CLR_RSET) v = '1;
      end
      v = (v & ~hc) | hs;
      if (e == FM_RSVD) v = '0;
      return v;
   endfunction

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                        input string tag, input int m);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s mode %0d: actual %h expected %h", tag, m, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic rd, input logic [W-1:0] wd,
         input logic [1:0] be, input logic [W-1:0] hv,
         input logic [W-1:0] hs, input logic [W-1:0] hc);
      b_wr = wr; b_rd = rd; b_wd = wd; b_be = be;
      h_val = hv; h_set = hs; h_clr = hc;
      #1;
      for (int i = 0; i < NM; i++) begin
         check(rd_arr[i], (can_read(i) && rd) ? mq[i] : '0, "R8", i);
      end
      for (int i = 0; i < NM; i++) begin
         logic once = (i == int'(FM_ONCE_RW) || i == int'(FM_ONCE_WO));
         mq[i]  = model_next(i, mq[i], mlk[i], wr, rd, wd, be, hv, hs, hc);
         mlk[i] = once && (mlk[i] || wr);
      end
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < NM; i++) check(q_arr[i], mq[i], req_of(i), i);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      b_wr = 0; b_rd = 0; b_wd = '0; b_be = '0;
      h_val = '0; h_set = '0; h_clr = '0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < NM; i++) begin
         mq[i]  = (i == int'(FM_RSVD)) ? '0 : RV;
         mlk[i] = 1'b0;
         check(q_arr[i], mq[i], "R1", i);   // R1 reset value
      end
      rst_n = 1'b1;
      // R7 / R1: first write lands, second is ignored by write-once modes
      step(1, 0, 16'h1234, 2'b11, '0, '0, '0);
      step(1, 0, 16'hFFFF, 2'b11, '0, '0, '0);
   endtask

   task automatic random_run(input int n);
      for (int k = 0; k < n; k++) begin
         logic [31:0] r, s;
         seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
         r = seed;
         seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
         s = seed;
         step(r[0], r[1] & r[2], r[23:8], r[4:3], s[31:16],
              (s[0] & s[1] & s[2]) ? (s[15:0] & r[31:16]) : '0,
              (s[3] & s[4] & s[5]) ? (s[15:0] | r[15:0])  : '0);
      end
   endtask

   initial begin
      do_reset();
      // R12: idle cycle, nothing may move except the hardware-fed field
      step(0, 0, 16'hFFFF, 2'b11, '0, '0, '0);
      random_run(9000);
      // R10: hardware set and clear against a full read+write
      step(1, 1, 16'hFFFF, 2'b11, 16'h5A5A, 16'h000F, 16'h00FF);
      for (int i = 0; i < NM; i++)
         if (i != int'(FM_RSVD)) check(q_arr[i] & 16'h00FF, 16'h000F, "R10", i);
      // R11: read effect applied after write effect
      step(1, 1, 16'hFFFF, 2'b11, '0, '0, '0);
      check(q_arr[int'(FM_W1CLR_RSET)], 16'hFFFF, "R11", int'(FM_W1CLR_RSET));
      check(q_arr[int'(FM_W1SET_RCLR)], 16'h0000, "R11", int'(FM_W1SET_RCLR));
      // R1: reset in mid-run re-arms write-once
      do_reset();
      random_run(9000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule